// File: doc/BRIEF.md
# Layered Sprite Pixel Compositor

The compositor merges up to eight sprite layers into one RGB 5:6:5 output pixel. For every output pixel it receives one candidate pixel per layer, together with a per-layer coverage flag and per-layer settings. The settings are pixel format, depth rank, enable, colour key and two alpha values. Each candidate is decoded into a 5:6:5 colour and a 4-bit weight. Layers 1 and up are sorted by depth rank, and the stack is blended from back to front over layer 0. Layer 0 is always the opaque base.

The block sits between the sprite fetch logic and the frame writer. It accepts one pixel per clock and produces each result a fixed two cycles later. The settings are sampled together with the pixel, so they may change from one pixel to the next.

Top module: `sprite_compositor`

## Requirements
- R1: While `in_valid` is high, one pixel is accepted per clock. `out_valid` rises exactly two clocks after the matching `in_valid`, and results leave in input order.
- R2: The per-layer format code selects the layout. Code 0 is RGB 5:6:5 (R in bits 15:11, G in 10:5, B in 4:0). Code 1 is ARGB 1:5:5:5 (A in bit 15, R in 14:10, G in 9:5, B in 4:0). Code 2 is ARGB 4:4:4:4 (A in 15:12, R in 11:8, G in 7:4, B in 3:0). Code 3 is treated as code 0. A channel narrower than its output field is widened by appending its own top bits.
- R3: A code-0 layer whose pixel equals that layer's key contributes nothing. A code-0 pixel that differs from the key has weight 15.
- R4: In code 1, alpha bit 0 selects the layer's first alpha value and alpha bit 1 selects its second.
- R5: In code 2, the top nibble is used directly as the weight.
- R6: Each channel becomes (w·fg + (15−w)·bg + 7) / 15, with integer division. Weight 0 leaves the background unchanged, and weight 15 replaces it.
- R7: Layers 1 to 7 are stacked by their 3-bit rank, and a larger rank is nearer the front. Where two ranks are equal, the higher layer index is in front.
- R8: A layer 1 to 7 whose enable bit or coverage flag is low is skipped.
- R9: Layer 0 is painted first, fully opaque, whatever its rank, enable, coverage, key or alpha values. In codes 1 and 2 only its colour bits are used.
- R10: Reset clears `out_valid` and `out_pix` to zero. `out_pix` keeps its last value while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel candidates present |
| in_pix | input | 16·NUM_LAYERS | Candidate pixel, layer i at bits i·16 +: 16 |
| in_cover | input | NUM_LAYERS | Layer i covers this pixel |
| cfg_fmt | input | 2·NUM_LAYERS | Format code per layer |
| cfg_zord | input | Z_W·NUM_LAYERS | Depth rank per layer |
| cfg_en | input | NUM_LAYERS | Layer enable |
| cfg_key | input | 16·NUM_LAYERS | Colour key per layer |
| cfg_alpha_lo | input | 4·NUM_LAYERS | Weight chosen when the 1-bit alpha is 0 |
| cfg_alpha_hi | input | 4·NUM_LAYERS | Weight chosen when the 1-bit alpha is 1 |
| out_valid | output | 1 | Result present |
| out_pix | output | 16 | Blended RGB 5:6:5 pixel |

## Verification
The bench builds the block with its defaults: NUM_LAYERS = 8 and Z_W = 3. With these values all seven upper layers can compete at every rank from 0 to 7. That reaches full ties at the top rank and stacks in which all eight layers contribute. A long run of pixels with randomised settings changes the format, key, rank and coverage of every layer from pixel to pixel. It includes back-to-back pixels and idle gaps, so the latency and the held output are exercised along with the colour arithmetic.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        FMT_RGB565   = 2'd0,
        FMT_ARGB1555 = 2'd1,
        FMT_ARGB4444 = 2'd2,
        FMT_ALIAS565 = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } rgb565_t;

    typedef struct packed {
        rgb565_t    c;
        logic [3:0] w;
    } layer_t;

    localparam logic [3:0] W_FULL = 4'd15;

    // weighted mix of one channel, up to 6 bits wide
    function automatic logic [5:0] mix_ch(input logic [5:0] f,
                                          input logic [5:0] b,
                                          input logic [3:0] w);
        logic [9:0] acc;
        acc = 10'(w) * 10'(f) + 10'(W_FULL - w) * 10'(b) + 10'd7;
        return 6'(acc / 10'd15);
    endfunction

endpackage

// File: rtl/spc_decode.sv
module spc_decode
    import spc_pkg::*;
#(
    parameter bit IS_BASE = 1'b0
) (
    input  logic [15:0] pix,
    input  logic [1:0]  fmt,
    input  logic [15:0] key,
    input  logic [3:0]  alpha_lo,
    input  logic [3:0]  alpha_hi,
    input  logic        live,
    output layer_t      lay
);

    layer_t raw;

    always_comb begin
        raw = '0;
        unique case (pix_fmt_e'(fmt))
            FMT_ARGB1555: begin
                raw.c.r = pix[14:10];
                raw.c.g = {pix[9:5], pix[9]};
                raw.c.b = pix[4:0];
                raw.w   = pix[15] ? alpha_hi : alpha_lo;
            end
            FMT_ARGB4444: begin
                raw.c.r = {pix[11:8], pix[11]};
                raw.c.g = {pix[7:4], pix[7:6]};
                raw.c.b = {pix[3:0], pix[3]};
                raw.w   = pix[15:12];
            end
            FMT_RGB565, FMT_ALIAS565: begin
                raw.c = rgb565_t'(pix);
                raw.w = (pix == key) ? 4'd0 : W_FULL;
            end
        endcase
    end

    always_comb begin
        lay = raw;
        if (IS_BASE)
            lay.w = W_FULL;
        else if (!live)
            lay.w = 4'd0;
    end

endmodule

// File: rtl/spc_order.sv
module spc_order #(
    parameter int NUM_LAYERS = 8,
    parameter int Z_W        = 3,
    localparam int IDX_W     = $clog2(NUM_LAYERS)
) (
    input  logic [NUM_LAYERS*Z_W-1:0]       zord,
    output logic [(NUM_LAYERS-1)*IDX_W-1:0] sel
);

    logic [IDX_W-1:0] pos [1:NUM_LAYERS-1];

    // position = number of upper layers lying behind this one
    always_comb begin
        for (int i = 1; i < NUM_LAYERS; i++) begin
            pos[i] = '0;
            for (int j = 1; j < NUM_LAYERS; j++) begin
                if (j != i) begin
                    if ((zord[j*Z_W +: Z_W] < zord[i*Z_W +: Z_W]) ||
                        ((zord[j*Z_W +: Z_W] == zord[i*Z_W +: Z_W]) && (j < i)))
                        pos[i] = pos[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        sel = '0;
        for (int s = 0; s < NUM_LAYERS - 1; s++) begin
            for (int i = 1; i < NUM_LAYERS; i++) begin
                if (pos[i] == IDX_W'(s))
                    sel[s*IDX_W +: IDX_W] = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/spc_blend.sv
module spc_blend
    import spc_pkg::*;
(
    input  rgb565_t bg,
    input  layer_t  fg,
    output rgb565_t mix
);

    logic [5:0] r6, b6;

    always_comb begin
        r6    = mix_ch({1'b0, fg.c.r}, {1'b0, bg.r}, fg.w);
        b6    = mix_ch({1'b0, fg.c.b}, {1'b0, bg.b}, fg.w);
        mix.r = r6[4:0];
        mix.g = mix_ch(fg.c.g, bg.g, fg.w);
        mix.b = b6[4:0];
    end

endmodule

// File: rtl/sprite_compositor.sv
module sprite_compositor
    import spc_pkg::*;
#(
    parameter int NUM_LAYERS = 8,
    parameter int Z_W        = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NUM_LAYERS*16-1:0]  in_pix,
    input  logic [NUM_LAYERS-1:0]     in_cover,
    input  logic [NUM_LAYERS*2-1:0]   cfg_fmt,
    input  logic [NUM_LAYERS*Z_W-1:0] cfg_zord,
    input  logic [NUM_LAYERS-1:0]     cfg_en,
    input  logic [NUM_LAYERS*16-1:0]  cfg_key,
    input  logic [NUM_LAYERS*4-1:0]   cfg_alpha_lo,
    input  logic [NUM_LAYERS*4-1:0]   cfg_alpha_hi,
    output logic                      out_valid,
    output logic [15:0]               out_pix
);

    localparam int IDX_W = $clog2(NUM_LAYERS);
    localparam int UPPER = NUM_LAYERS - 1;

    layer_t                   dec [NUM_LAYERS];
    logic [UPPER*IDX_W-1:0]   sel;
    layer_t                   ord_c [UPPER];

    logic                     s1_valid;
    rgb565_t                  s1_base;
    layer_t                   s1_ord [UPPER];
    rgb565_t                  mix [NUM_LAYERS];

    // stage 1: decode every layer
    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_dec
        spc_decode #(.IS_BASE(g == 0)) u_dec (
            .pix      (in_pix[g*16 +: 16]),
            .fmt      (cfg_fmt[g*2 +: 2]),
            .key      (cfg_key[g*16 +: 16]),
            .alpha_lo (cfg_alpha_lo[g*4 +: 4]),
            .alpha_hi (cfg_alpha_hi[g*4 +: 4]),
            .live     (cfg_en[g] & in_cover[g]),
            .lay      (dec[g])
        );
    end

    spc_order #(.NUM_LAYERS(NUM_LAYERS), .Z_W(Z_W)) u_order (
        .zord (cfg_zord),
        .sel  (sel)
    );

    always_comb begin
        for (int s = 0; s < UPPER; s++)
            ord_c[s] = dec[sel[s*IDX_W +: IDX_W]];
    end

    always_ff @(posedge clk) begin
        s1_base <= dec[0].c;
        for (int s = 0; s < UPPER; s++)
            s1_ord[s] <= ord_c[s];
    end

    // stage 2: back-to-front blend chain
    assign mix[0] = s1_base;
    for (genvar k = 0; k < UPPER; k++) begin : g_blend
        spc_blend u_blend (
            .bg  (mix[k]),
            .fg  (s1_ord[k]),
            .mix (mix[k+1])
        );
    end

    // pipeline control and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
            if (s1_valid)
                out_pix <= mix[UPPER];
        end
    end

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int NUM_LAYERS = 8,
    parameter int Z_W        = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [NUM_LAYERS*16-1:0]  in_pix,
    input logic [NUM_LAYERS-1:0]     in_cover,
    input logic [NUM_LAYERS*2-1:0]   cfg_fmt,
    input logic [NUM_LAYERS*Z_W-1:0] cfg_zord,
    input logic [NUM_LAYERS-1:0]     cfg_en,
    input logic [NUM_LAYERS*16-1:0]  cfg_key,
    input logic                      out_valid,
    input logic [15:0]               out_pix
);

    localparam int TOP = NUM_LAYERS - 1;

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    logic upper_live;
    logic top_opaque;
    assign upper_live = |(in_cover[NUM_LAYERS-1:1] & cfg_en[NUM_LAYERS-1:1]);
    assign top_opaque = cfg_en[TOP] && in_cover[TOP] &&
                        (cfg_fmt[TOP*2] == 1'b0) && (cfg_fmt[TOP*2+1] == 1'b0) &&
                        (&cfg_zord[TOP*Z_W +: Z_W]) &&
                        (in_pix[TOP*16 +: 16] != cfg_key[TOP*16 +: 16]);

    // R1: fixed two-cycle latency
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R9: with no live upper layer, a 5:6:5 base passes unchanged
    p_base_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 2'd2) && $past(in_valid, 2) && !$past(upper_live, 2) &&
         ($past(cfg_fmt[1:0], 2) == 2'd0))
        |-> (out_pix == $past(in_pix[15:0], 2)));

    // R7: top-index layer at the highest rank and opaque wins every tie
    p_top_front_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 2'd2) && $past(in_valid, 2) && $past(top_opaque, 2))
        |-> (out_pix == $past(in_pix[TOP*16 +: 16], 2)));

    // R10: output held while no result is presented
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 2'd1) && !out_valid) |-> $stable(out_pix));

endmodule

bind sprite_compositor spc_checker #(.NUM_LAYERS(NUM_LAYERS), .Z_W(Z_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .in_cover  (in_cover),
    .cfg_fmt   (cfg_fmt),
    .cfg_zord  (cfg_zord),
    .cfg_en    (cfg_en),
    .cfg_key   (cfg_key),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/sprite_compositor_test.sv
module sprite_compositor_test;

    localparam int N  = 8;
    localparam int ZW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [N*16-1:0]   in_pix = '0;
    logic [N-1:0]      in_cover = '0;
    logic [N*2-1:0]    cfg_fmt = '0;
    logic [N*ZW-1:0]   cfg_zord = '0;
    logic [N-1:0]      cfg_en = '0;
    logic [N*16-1:0]   cfg_key = '0;
    logic [N*4-1:0]    cfg_alpha_lo = '0;
    logic [N*4-1:0]    cfg_alpha_hi = '0;
    logic              out_valid;
    logic [15:0]       out_pix;

    sprite_compositor #(.NUM_LAYERS(N), .Z_W(ZW)) uut (.*);

    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] b_pix [N];
    logic [1:0]  b_fmt [N];
    int          b_z   [N];
    logic        b_en  [N];
    logic        b_cov [N];
    logic [15:0] b_key [N];
    logic [3:0]  b_lo  [N];
    logic [3:0]  b_hi  [N];

    logic [15:0] q_pix [$];
    int          q_cyc [$];
    string       q_tag [$];
    logic [15:0] last_pix = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void unpack(input int i, output int r, output int g,
                                   output int b, output int w);
        int p = b_pix[i];
        int t;
        case (b_fmt[i])
            2'd1: begin
                r = (p >> 10) & 31;
                t = (p >> 5) & 31;  g = t * 2 + (t >> 4);
                b = p & 31;
                w = p[15] ? b_hi[i] : b_lo[i];
            end
            2'd2: begin
                t = (p >> 8) & 15;  r = t * 2 + (t >> 3);
                t = (p >> 4) & 15;  g = t * 4 + (t >> 2);
                t = p & 15;         b = t * 2 + (t >> 3);
                w = (p >> 12) & 15;
            end
            default: begin
                r = (p >> 11) & 31;
                g = (p >> 5) & 63;
                b = p & 31;
                w = (b_pix[i] == b_key[i]) ? 0 : 15;
            end
        endcase
    endfunction

    function automatic int mixv(input int f, input int bg, input int w);
        return (w * f + (15 - w) * bg + 7) / 15;
    endfunction

    function automatic logic [15:0] model();
        int r, g, b, w, fr, fg, fb;
        unpack(0, r, g, b, w);
        for (int lvl = 0; lvl < (1 << ZW); lvl++)
            for (int i = 1; i < N; i++)
                if (b_z[i] == lvl && b_en[i] && b_cov[i]) begin
                    unpack(i, fr, fg, fb, w);
                    r = mixv(fr, r, w);
                    g = mixv(fg, g, w);
                    b = mixv(fb, b, w);
                end
        return {5'(r), 6'(g), 5'(b)};
    endfunction

    task automatic defaults();
        for (int i = 0; i < N; i++) begin
            b_pix[i] = 16'h0000; b_fmt[i] = 2'd0; b_z[i] = 0;
            b_en[i] = 1'b0; b_cov[i] = 1'b1; b_key[i] = 16'h0000;
            b_lo[i] = 4'd0; b_hi[i] = 4'd0;
        end
    endtask

    task automatic send(input string tag);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            in_pix[i*16 +: 16]     = b_pix[i];
            cfg_fmt[i*2 +: 2]      = b_fmt[i];
            cfg_zord[i*ZW +: ZW]   = ZW'(b_z[i]);
            cfg_en[i]              = b_en[i];
            in_cover[i]            = b_cov[i];
            cfg_key[i*16 +: 16]    = b_key[i];
            cfg_alpha_lo[i*4 +: 4] = b_lo[i];
            cfg_alpha_hi[i*4 +: 4] = b_hi[i];
        end
        in_valid = 1'b1;
        q_pix.push_back(model());
        q_cyc.push_back(cyc + 2);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (q_pix.size() == 0) begin
                    check(1'b0, "R1 unexpected output", int'(out_pix), 0);
                end else begin
                    logic [15:0] e;
                    int ec;
                    string t;
                    e = q_pix.pop_front(); ec = q_cyc.pop_front(); t = q_tag.pop_front();
                    check(ec == cyc, {"R1 latency ", t}, cyc, ec);
                    check(out_pix == e, t, int'(out_pix), int'(e));
                end
                last_pix = out_pix;
            end else begin
                check(out_pix == last_pix, "R10 hold", int'(out_pix), int'(last_pix));
            end
        end
    end

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        defaults();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_pix == 16'h0, "R10 reset", int'(out_pix), 0);
        rst_n = 1'b1;

        // R9 base alone, all upper disabled
        b_pix[0] = 16'h001F; send("R9 base only");
        // R9 base in 4444 with zero alpha still opaque
        b_fmt[0] = 2'd2; b_pix[0] = 16'h0A5C; send("R9 base alpha ignored");
        // R2 1555 base colour widening
        b_fmt[0] = 2'd1; b_pix[0] = 16'h7FE1; send("R2 base 1555 widen");
        b_fmt[0] = 2'd0; b_pix[0] = 16'h001F;
        // R6 opaque 565 layer over base
        b_en[3] = 1'b1; b_pix[3] = 16'hF800; b_key[3] = 16'h0000; send("R6 opaque replace");
        // R3 key match
        b_key[3] = 16'hF800; send("R3 key transparent");
        // R2 format code 3 acts as 565 with key
        b_fmt[3] = 2'd3; send("R2 alias code keyed");
        b_key[3] = 16'h1234; send("R2 alias code opaque");
        b_fmt[3] = 2'd0; b_key[3] = 16'h0000;
        // R8 coverage low and enable low
        b_cov[3] = 1'b0; send("R8 coverage low");
        b_cov[3] = 1'b1; b_en[3] = 1'b0; send("R8 enable low");
        b_en[3] = 1'b1;
        // R4 1555 alpha select
        b_fmt[3] = 2'd1; b_lo[3] = 4'd0; b_hi[3] = 4'd8;
        b_pix[3] = 16'h7C00; send("R4 alpha bit 0 weight 0");
        b_pix[3] = 16'hFC00; send("R4 alpha bit 1 weight 8");
        b_hi[3] = 4'd15; send("R4 alpha bit 1 weight 15");
        // R5 4444 direct alpha
        b_fmt[3] = 2'd2; b_pix[3] = 16'h7F0F; send("R5 nibble weight 7");
        b_pix[3] = 16'h0FFF; send("R5 nibble weight 0");
        // R7 ordering: two opaque layers, then swap ranks, then tie
        b_fmt[3] = 2'd0; b_pix[3] = 16'hF800; b_z[3] = 2;
        b_en[5] = 1'b1; b_pix[5] = 16'h07E0; b_z[5] = 5;
        send("R7 higher rank front");
        b_z[3] = 6; send("R7 swapped rank");
        b_z[3] = 4; b_z[5] = 4; send("R7 tie higher index");
        b_z[0] = 7; send("R9 base rank ignored");
        // R6 mixed stack of translucent layers
        for (int i = 1; i < N; i++) begin
            b_en[i] = 1'b1; b_fmt[i] = 2'd2; b_z[i] = N - i;
            b_pix[i] = 16'((i * 16'h1357) | 16'h5000);
        end
        send("R6 eight layer stack");
        idle(3);

        // randomised stream with gaps
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < N; i++) begin
                b_pix[i] = 16'($urandom);
                b_fmt[i] = 2'($urandom % 4);
                b_z[i]   = $urandom % 8;
                b_en[i]  = ($urandom % 4) != 0;
                b_cov[i] = ($urandom % 4) != 0;
                b_key[i] = (($urandom % 3) == 0) ? b_pix[i] : 16'($urandom);
                b_lo[i]  = 4'($urandom);
                b_hi[i]  = 4'($urandom);
            end
            send("R6 R7 random stream");
            if (($urandom % 4) == 0) idle(1 + $urandom % 3);
        end
        idle(6);
        check(q_pix.size() == 0, "R1 outstanding results", q_pix.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule